// File: doc/BRIEF.md
# Write-Through Data Cache with Switchable Write Allocation and Line Fill

This block is a 256-byte direct-mapped data cache that sits between a core's load/store port and a memory port. It is organised as 16 lines of four 32-bit longwords. Each longword has its own valid bit, so a partial line can be resident. Every store is passed straight through to memory. Whether a store that misses also places its data in the cache is chosen at run time by an allocate control. On a read miss a burst control picks one of two fill modes. The first fetches the whole four-longword line in a single transfer, starting at the line-aligned address with beats in ascending order. The second fetches only the missing longword. During a burst the requested longword goes back to the core on the beat that carries it.

Software sets the cache up through one 32-bit control register. That register also holds the instruction-cache controls, which are stored and read back but have no effect here. The data-cache controls are:
- enable;
- freeze, which keeps hits working but blocks every fill, including write allocation;
- clear-all and clear-line, two self-clearing commands that read back as zero;
- burst;
- allocate.

Clear-line drops the line named on a separate index input.

The core issues one request at a time. The request is taken when `req_ready` is high. It completes with a one-cycle `rsp_valid` pulse. For reads this pulse carries the data. For writes it comes after memory has taken the data. Memory transfers hold `mem_req`, and memory answers each beat with `mem_ack`.

Top module: `dc_wt_cache`

## Requirements
- R1: After reset the control register reads 0, the cache is disabled with every longword invalid, `req_ready` is 1 and `mem_req` and `rsp_valid` are 0.
- R2: Control bits sit at: instruction enable 0, instruction freeze 1, instruction clear-line 2, instruction clear-all 3, instruction burst 4, data enable 8, data freeze 9, data clear-line 10, data clear-all 11, data burst 12, allocate 13. Bits 0, 1, 4, 8, 9, 12 and 13 are stored and read back. Bits 2, 3, 10, 11 and all unused bits always read 0, so writing all ones reads back 0x00003313.
- R3: With data enable 0, every read goes to memory as a single-longword transfer, whatever the burst bit says, and nothing is filled. A repeated read goes to memory again.
- R4: A read that hits returns the cached longword with no memory transfer, and `rsp_valid` is high in the second cycle after the request is accepted.
- R5: With enable set, burst set and freeze clear, a read miss issues one burst (`mem_burst`=1) at the line-aligned address of four beats in ascending order. The response carries the requested longword. Afterwards all four longwords of the line hit.
- R6: With burst clear, a read miss issues one single-longword transfer at the requested address. Only that longword becomes valid, and a neighbour in the same line still misses.
- R7: Every write issues a single-beat memory write with the request's word address and data, whether it hits or misses. While `mem_req` is high and no beat is acknowledged, the address, direction and burst flag hold.
- R8: A write that hits updates the cached longword, so a following read hits and returns the new data.
- R9: With allocate clear, a write miss leaves the cache unchanged and a later read of that address misses. With allocate set, a write miss installs only that longword: it then hits, while a neighbour in the same line misses.
- R10: With freeze set, hits are still served, but read misses fill nothing and use single-longword transfers. Write-miss allocation is suppressed, while a write hit still updates the cache.
- R11: Writing the control register with the data clear-all bit set invalidates every line.
- R12: Writing the control register with the data clear-line bit set invalidates only the line given on `ctl_entry`; other lines keep hitting.
- R13: A fill to a line that holds a different tag replaces the line, and the old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_entry | input | 4 | Line index used by the clear-line command |
| ctl_rdata | output | 32 | Control register read value |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid on reads |
| mem_req | output | 1 | Memory transfer active |
| mem_we | output | 1 | Memory transfer is a write |
| mem_burst | output | 1 | Memory transfer is a four-beat line read |
| mem_addr | output | 32 | Word-aligned (single) or line-aligned (burst) address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepted or returned one beat |
| mem_rdata | input | 32 | Memory read data for the acknowledged beat |

## Verification
The lookup is tried with several patterns:
- repeated reads of one address, which separate a hit from an unfilled miss;
- reads of neighbouring longwords after single-longword and burst fills, which tell per-longword validity from whole-line validity;
- reads of two addresses that share a line index but differ in tag, which expose missing tag replacement.

Stores are run as hit, as miss with allocate clear and as miss with allocate set, each followed by a read. This shows whether the cache, memory or both were updated. The freeze, clear-line and clear-all commands are each followed by reads of a targeted line and an untouched line, and the memory transfer count shows which ones still hit.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int BIT_EI  = 0;
  localparam int BIT_FI  = 1;
  localparam int BIT_CEI = 2;
  localparam int BIT_CI  = 3;
  localparam int BIT_IBE = 4;
  localparam int BIT_ED  = 8;
  localparam int BIT_FD  = 9;
  localparam int BIT_CED = 10;
  localparam int BIT_CD  = 11;
  localparam int BIT_DBE = 12;
  localparam int BIT_WA  = 13;

  // Bits that hold state; command bits and unused bits are never stored.
  localparam logic [31:0] KEEP_MASK =
      (32'd1 << BIT_EI) | (32'd1 << BIT_FI) | (32'd1 << BIT_IBE) |
      (32'd1 << BIT_ED) | (32'd1 << BIT_FD) | (32'd1 << BIT_DBE) |
      (32'd1 << BIT_WA);

  typedef struct packed {
    logic en;
    logic frz;
    logic burst;
    logic walloc;
  } dc_mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FETCH, ST_WRITE} dc_state_t;
endpackage

// File: rtl/dc_ctl_reg.sv
module dc_ctl_reg
  import dc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  output dc_mode_t    mode,
  output logic        clr_all,
  output logic        clr_line
);
  logic [31:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst)         reg_q <= '0;
    else if (ctl_we) reg_q <= ctl_wdata & KEEP_MASK;
  end

  assign ctl_rdata   = reg_q;
  assign mode.en     = reg_q[BIT_ED];
  assign mode.frz    = reg_q[BIT_FD];
  assign mode.burst  = reg_q[BIT_DBE];
  assign mode.walloc = reg_q[BIT_WA];
  // Commands act at the edge that writes them and are never stored.
  assign clr_all  = ctl_we & ctl_wdata[BIT_CD];
  assign clr_line = ctl_we & ctl_wdata[BIT_CED];
endmodule

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int TAGW  = 24,
  localparam int IDXW = $clog2(LINES),
  localparam int OFFW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all,
  input  logic            clr_line,
  input  logic [IDXW-1:0] clr_idx,
  input  logic [IDXW-1:0] lk_idx,
  input  logic [OFFW-1:0] lk_off,
  input  logic [TAGW-1:0] lk_tag,
  output logic            hit,
  input  logic            upd_en,
  input  logic [IDXW-1:0] upd_idx,
  input  logic [TAGW-1:0] upd_tag,
  input  logic [WORDS-1:0] upd_mask
);
  logic [WORDS-1:0] valid_q [LINES];
  logic [TAGW-1:0]  tag_q   [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || clr_all || (clr_line && clr_idx == IDXW'(l))) begin
        valid_q[l] <= '0;
      end else if (upd_en && upd_idx == IDXW'(l)) begin
        tag_q[l]   <= upd_tag;
        // A new tag discards what the line held; the same tag accumulates.
        valid_q[l] <= ((tag_q[l] == upd_tag) ? valid_q[l] : '0) | upd_mask;
      end
    end
  end

  assign hit = valid_q[lk_idx][lk_off] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/dc_data_ram.sv
module dc_data_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/dc_wt_cache.sv
module dc_wt_cache
  import dc_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW  = $clog2(LINES),
  localparam int OFFW  = $clog2(WORDS),
  localparam int BYTEW = $clog2(DW / 8),
  localparam int TAGW  = AW - BYTEW - OFFW - IDXW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic [31:0]     ctl_wdata,
  input  logic [IDXW-1:0] ctl_entry,
  output logic [31:0]     ctl_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_burst,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int RAMAW = IDXW + OFFW;
  localparam logic [AW-1:0] WORD_MASK = AW'((1 << BYTEW) - 1);
  localparam logic [AW-1:0] LINE_MASK = AW'((1 << (BYTEW + OFFW)) - 1);
  localparam logic [OFFW-1:0] LAST_BEAT = OFFW'(WORDS - 1);

  dc_mode_t  mode;
  logic      clr_all, clr_line;
  dc_state_t state_q;
  logic            a_we_q, burst_q, fill_q;
  logic [AW-1:0]   a_addr_q;
  logic [DW-1:0]   a_wdata_q;
  logic [OFFW-1:0] beat_q;
  logic [IDXW-1:0] a_idx;
  logic [OFFW-1:0] a_off;
  logic [TAGW-1:0] a_tag;
  logic            hit, cache_wr, use_burst;
  logic            ram_we, upd_en;
  logic [OFFW-1:0] upd_off;
  logic [DW-1:0]   ram_wdata, ram_q;

  dc_ctl_reg u_ctl (
    .clk, .rst, .ctl_we, .ctl_wdata, .ctl_rdata,
    .mode, .clr_all, .clr_line
  );

  assign a_off = a_addr_q[BYTEW +: OFFW];
  assign a_idx = a_addr_q[BYTEW + OFFW +: IDXW];
  assign a_tag = a_addr_q[AW-1 -: TAGW];

  assign req_ready = (state_q == ST_IDLE);
  assign cache_wr  = mode.en && (hit || (mode.walloc && !mode.frz));
  assign use_burst = mode.en && !mode.frz && mode.burst;

  // One write port shared by store updates (lookup cycle) and fills (beats).
  always_comb begin
    ram_we    = 1'b0;
    upd_off   = a_off;
    ram_wdata = a_wdata_q;
    if (state_q == ST_LOOK && a_we_q && cache_wr) begin
      ram_we = 1'b1;
    end else if (state_q == ST_FETCH && mem_ack && fill_q) begin
      ram_we    = 1'b1;
      upd_off   = burst_q ? beat_q : a_off;
      ram_wdata = mem_rdata;
    end
  end
  assign upd_en = ram_we;

  dc_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAGW(TAGW)) u_tags (
    .clk, .rst, .clr_all, .clr_line, .clr_idx(ctl_entry),
    .lk_idx(a_idx), .lk_off(a_off), .lk_tag(a_tag), .hit,
    .upd_en, .upd_idx(a_idx), .upd_tag(a_tag),
    .upd_mask(WORDS'(1) << upd_off)
  );

  dc_data_ram #(.DEPTH(LINES * WORDS), .DW(DW)) u_ram (
    .clk, .we(ram_we), .waddr({a_idx, upd_off}), .wdata(ram_wdata),
    .raddr(req_addr[BYTEW +: RAMAW]), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_burst <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      a_we_q    <= 1'b0;
      a_addr_q  <= '0;
      a_wdata_q <= '0;
      beat_q    <= '0;
      burst_q   <= 1'b0;
      fill_q    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          a_we_q    <= req_we;
          a_addr_q  <= req_addr;
          a_wdata_q <= req_wdata;
          state_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (a_we_q) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_burst <= 1'b0;
            mem_addr  <= a_addr_q & ~WORD_MASK;
            mem_wdata <= a_wdata_q;
            state_q   <= ST_WRITE;
          end else if (mode.en && hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= ram_q;
            state_q   <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            mem_burst <= use_burst;
            mem_addr  <= a_addr_q & ~(use_burst ? LINE_MASK : WORD_MASK);
            burst_q   <= use_burst;
            fill_q    <= mode.en && !mode.frz;
            beat_q    <= '0;
            state_q   <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ack) begin
          if (!burst_q || beat_q == a_off) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_rdata;
          end
          if (!burst_q || beat_q == LAST_BEAT) begin
            mem_req   <= 1'b0;
            mem_burst <= 1'b0;
            state_q   <= ST_IDLE;
          end
          beat_q <= beat_q + 1'b1;
        end
        ST_WRITE: if (mem_ack) begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          rsp_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_wt_cache_chk.sv
module dc_wt_cache_chk #(
  parameter int AW  = 32,
  parameter int LOW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   ctl_rdata,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_burst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  localparam logic [31:0] STORED = 32'h0000_3313;

  // R1: first cycle out of reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !rsp_valid));

  // R2: command and unused bits never read back
  p_ctl_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata & ~STORED) == 32'd0);

  // R5: bursts start line aligned
  p_burst_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_burst) |-> (mem_addr[LOW-1:0] == '0));

  // R5: bursts are reads only
  p_burst_read_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_burst) |-> !mem_we);

  // R7: transfer attributes hold until acknowledged
  p_mem_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_burst)));

  // R4: a completion with no transfer in flight leaves the cache ready
  p_rsp_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !mem_req) |-> req_ready);
endmodule

bind dc_wt_cache dc_wt_cache_chk #(.AW(AW), .LOW(BYTEW + OFFW)) u_chk (
  .clk(clk), .rst(rst), .ctl_rdata(ctl_rdata), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_we(mem_we),
  .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/dc_wt_cache_tb.sv
module dc_wt_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] C_ED = 32'h100, C_FD = 32'h200, C_CED = 32'h400,
                          C_CD = 32'h800, C_DBE = 32'h1000, C_WA = 32'h2000;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  logic [3:0] ctl_entry = '0;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, rsp_rdata;
  logic rsp_valid;
  logic mem_req, mem_we, mem_burst, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  logic [31:0] mem_model [4096];
  int n_checks = 0, n_errors = 0;
  int txn_cnt = 0, wr_cnt = 0, beat = 0;
  logic [31:0] last_addr = '0;
  logic last_burst = 1'b0;
  bit done = 1'b0;

  dc_wt_cache u_dut (
    .clk, .rst, .ctl_we, .ctl_wdata, .ctl_entry, .ctl_rdata,
    .req_valid, .req_ready, .req_we, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata,
    .mem_req, .mem_we, .mem_burst, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Memory model: one beat per cycle while a transfer is held.
  always @(negedge clk) begin
    if (mem_req) begin
      logic [11:0] wi;
      wi = mem_addr[13:2] + 12'(beat);
      if (beat == 0) begin
        txn_cnt++;
        last_addr  = mem_addr;
        last_burst = mem_burst;
        if (mem_we) wr_cnt++;
      end
      if (mem_we) mem_model[wi] = mem_wdata;
      else        mem_rdata = mem_model[wi];
      mem_ack = 1'b1;
      beat++;
    end else begin
      mem_ack = 1'b0;
      beat = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  task automatic ctl_write(input logic [31:0] v, input logic [3:0] entry);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v; ctl_entry = entry;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat, output int ntx);
    int t0;
    @(negedge clk);
    while (!req_ready || mem_req) @(negedge clk);
    t0 = txn_cnt;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    rd = '0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      lat++;
      if (rsp_valid) begin rd = rsp_rdata; break; end
    end
    while (!req_ready || mem_req) @(negedge clk);
    ntx = txn_cnt - t0;
  endtask

  task automatic rd_expect(input string req, input logic [31:0] addr, input int exp_tx);
    logic [31:0] rd; int lat, ntx; logic [31:0] exp;
    exp = mem_model[addr[13:2]];
    access(1'b0, addr, '0, rd, lat, ntx);
    chk({req, " data"}, rd, exp);
    chk({req, " transfers"}, ntx, exp_tx);
  endtask

  task automatic wr_do(input string req, input logic [31:0] addr, input logic [31:0] d);
    logic [31:0] rd; int lat, ntx, w0;
    w0 = wr_cnt;
    access(1'b1, addr, d, rd, lat, ntx);
    chk({req, " write transfer"}, wr_cnt - w0, 1);
    chk({req, " write addr"}, last_addr, addr);
    chk({req, " memory data"}, mem_model[addr[13:2]], d);
  endtask

  task automatic t_reset();
    chk("R1 ctl_rdata", ctl_rdata, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_register();
    ctl_write(32'hFFFF_FFFF, 4'd0);
    chk("R2 all-ones readback", ctl_rdata, 32'h0000_3313);
    ctl_write(C_ED | C_CD | C_CED, 4'd0);
    chk("R2 commands read zero", ctl_rdata, C_ED);
    ctl_write(32'h0, 4'd0);
    chk("R2 cleared", ctl_rdata, 0);
  endtask

  task automatic t_disabled();
    rd_expect("R1 first read misses", 32'h40, 1);
    rd_expect("R3 disabled repeat", 32'h40, 1);
    ctl_write(C_DBE, 4'd0);
    rd_expect("R3 disabled burst bit", 32'h44, 1);
    chk("R3 no burst when disabled", last_burst, 0);
  endtask

  task automatic t_single();
    logic [31:0] rd; int lat, ntx;
    ctl_write(C_ED, 4'd0);
    rd_expect("R6 single miss", 32'h104, 1);
    chk("R6 single addr", last_addr, 32'h104);
    chk("R6 single not burst", last_burst, 0);
    access(1'b0, 32'h104, '0, rd, lat, ntx);
    chk("R4 hit data", rd, mem_model[32'h104 >> 2]);
    chk("R4 hit no transfer", ntx, 0);
    chk("R4 hit latency", lat, 1);
    rd_expect("R6 neighbour misses", 32'h108, 1);
  endtask

  task automatic t_burst();
    ctl_write(C_ED | C_DBE, 4'd0);
    rd_expect("R5 burst miss", 32'h238, 1);
    chk("R5 burst flag", last_burst, 1);
    chk("R5 burst aligned addr", last_addr, 32'h230);
    rd_expect("R5 line word0 hits", 32'h230, 0);
    rd_expect("R5 line word1 hits", 32'h234, 0);
    rd_expect("R5 line word3 hits", 32'h23C, 0);
  endtask

  task automatic t_write_hit();
    wr_do("R7 write hit", 32'h234, 32'hDEAD_0234);
    rd_expect("R8 write hit updates cache", 32'h234, 0);
  endtask

  task automatic t_write_miss();
    ctl_write(C_ED, 4'd0);
    wr_do("R7 write miss", 32'h300, 32'h1111_0300);
    rd_expect("R9 no-allocate miss", 32'h300, 1);
    ctl_write(C_ED | C_WA, 4'd0);
    wr_do("R9 allocate write", 32'h344, 32'h2222_0344);
    rd_expect("R9 allocated hits", 32'h344, 0);
    rd_expect("R9 allocate neighbour misses", 32'h348, 1);
  endtask

  task automatic t_freeze();
    ctl_write(C_ED | C_FD | C_WA | C_DBE, 4'd0);
    rd_expect("R10 frozen hit", 32'h234, 0);
    rd_expect("R10 frozen miss", 32'h500, 1);
    chk("R10 frozen miss single", last_burst, 0);
    rd_expect("R10 frozen no fill", 32'h500, 1);
    wr_do("R10 frozen write miss", 32'h600, 32'h3333_0600);
    rd_expect("R10 allocate suppressed", 32'h600, 1);
    wr_do("R10 frozen write hit", 32'h238, 32'h4444_0238);
    rd_expect("R10 write hit updated", 32'h238, 0);
  endtask

  task automatic t_clears();
    ctl_write(C_ED | C_CED, 4'd3);
    rd_expect("R12 cleared line misses", 32'h230, 1);
    rd_expect("R12 other line hits", 32'h344, 0);
    ctl_write(C_ED | C_CD, 4'd0);
    rd_expect("R11 clear all misses", 32'h344, 1);
  endtask

  task automatic t_conflict();
    ctl_write(C_ED | C_DBE, 4'd0);
    rd_expect("R13 fill line", 32'h230, 1);
    rd_expect("R13 same index new tag", 32'h1230, 1);
    rd_expect("R13 old tag evicted", 32'h230, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_model[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0003);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_register();
    t_disabled();
    t_single();
    t_burst();
    t_write_hit();
    t_write_miss();
    t_freeze();
    t_clears();
    t_conflict();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule